// File: doc/BRIEF.md
# Fuse Program Pulse Sequencer

This block sequences one access to a serial one-time-programmable fuse macro. A requester raises `start_i` with an operation select, a word address, a data word (already masked so that only bits still to be blown are 1) and a packed timing word. For a program access the sequencer walks the data word from bit 0 upward, shifting it right with zero fill. Each bit holding 1 gets a program strobe bracketed by relax gaps. Each bit holding 0 is passed over without a strobe. A read access gives a single read strobe between two relax gaps and then captures the word that the macro returns.

All pulse widths come from fields of the timing word, counted in clock periods. A zero field is accepted but stretched to one cycle, so no phase ever collapses. A program access ends with a fixed quiet interval of `QUIET_CYC` cycles, sized to the fuse recovery time at the clock rate. Completion is signalled only after that interval. The timing word, address, data and operation are captured when a request is accepted. Requests that arrive while an access or its quiet interval is in progress are not accepted.

Top module: `fuse_pulse_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `fuse_pgm_o` and `fuse_rd_o` are 0 and `rdata_o` is 0.
- R2: A program access visits bit indices 0 to DATA_W-1 in ascending order. It gives exactly one program strobe for each 1 bit of the captured data and none for 0 bits. During each strobe, `fuse_bitsel_o` equals that bit's index and `fuse_bit_o` is 1.
- R3: Each program strobe lasts P cycles, where P is timing bits [11:0]. A value of 0 gives 1 cycle.
- R4: The relax count R is timing bits [15:12], and a value of 0 gives 1 cycle. A program access is busy for 2*DATA_W + ones*(2R+P) + QUIET_CYC + 1 cycles. This covers one evaluate cycle and one shift cycle per bit, plus R relax cycles before and after each strobe.
- R5: A read access gives one read strobe of D cycles, where D is timing bits [21:16] and a value of 0 gives 1 cycle. The access is busy for 2R+D+3 cycles. `rdata_o` then holds the macro word sampled in the cycle after the closing relax gap.
- R6: After the last bit of a program access, no strobe occurs for at least QUIET_CYC+1 cycles before busy falls. `done_o` is high for exactly one cycle, which is the last busy cycle.
- R7: A start request while busy is neither accepted nor queued. Changes to timing, data or address while busy do not affect the running access.
- R8: The program and read strobes are never high together. No strobe is high while idle. `fuse_addr_o` holds the captured address for the whole access.
- R9: `rdata_o` changes only in the done cycle of a read access. A program access leaves it unchanged.
- R10: Timing bits [31:22] have no effect on any pulse width or on the access length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Access request, accepted only when idle |
| op_prog_i | input | 1 | 1 = program access, 0 = read access |
| addr_i | input | ADDR_W | Fuse word address |
| wdata_i | input | DATA_W | Masked program data |
| timing_i | input | TIM_W | Packed timing word: program [11:0], relax [15:12], read [21:16] |
| macro_rdata_i | input | DATA_W | Word returned by the fuse macro |
| busy_o | output | 1 | Access in progress, including the quiet interval |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Last captured read word |
| fuse_addr_o | output | ADDR_W | Address to the macro |
| fuse_bitsel_o | output | $clog2(DATA_W) | Bit index being programmed |
| fuse_bit_o | output | 1 | Current serial data bit during a program access |
| fuse_pgm_o | output | 1 | Program strobe |
| fuse_rd_o | output | 1 | Read strobe |

## Verification
A corrupted phase counter or a wrong length selection shows up as a strobe of the wrong width, visible when that strobe falls. The total busy length also shifts, and that difference appears at the completion pulse. A damaged shift register or bit index shows up at the very next strobe as the wrong bit select, or as a strobe on a zero bit. A state machine that accepts a request while busy produces a second busy interval or a second done pulse within one cycle of the first one ending. The bench compares every access against cycle counts derived from the requirements, using random data and timing words mixed with zero fields, all-ones and all-zero data, and requests and input changes injected mid-access.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_EVAL,
      ST_PRE,
      ST_PGM,
      ST_RD,
      ST_POST,
      ST_SHIFT,
      ST_QUIET,
      ST_CAPT,
      ST_DONE
   } seq_state_e;

   localparam int NUM_FIELDS = 3;
   localparam int FLD_PGM    = 0;
   localparam int FLD_RLX    = 1;
   localparam int FLD_RD     = 2;

endpackage

// File: rtl/fuse_field_len.sv
module fuse_field_len #(
   parameter int FW    = 12,
   parameter int CNT_W = 12
) (
   input  logic [FW-1:0]    field_i,
   output logic [CNT_W-1:0] len_m1_o
);

   // a zero field still yields one cycle: length-1 of zero
   assign len_m1_o = (field_i == '0) ? '0 : CNT_W'(field_i - 1'b1);

endmodule

// File: rtl/fuse_timing_unpack.sv
module fuse_timing_unpack
   import fuse_seq_pkg::*;
#(
   parameter int TIM_W   = 32,
   parameter int PGM_LSB = 0,
   parameter int PGM_W   = 12,
   parameter int RLX_LSB = 12,
   parameter int RLX_W   = 4,
   parameter int RD_LSB  = 16,
   parameter int RD_W    = 6,
   parameter int CNT_W   = 12
) (
   input  logic [TIM_W-1:0] timing_i,
   output logic [CNT_W-1:0] pgm_len_o,
   output logic [CNT_W-1:0] rlx_len_o,
   output logic [CNT_W-1:0] rd_len_o
);

   logic [NUM_FIELDS-1:0][CNT_W-1:0] lens;
   logic                             unused_word;

   assign unused_word = ^timing_i;

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
      localparam int FL = (g == FLD_PGM) ? PGM_LSB : (g == FLD_RLX) ? RLX_LSB : RD_LSB;
      localparam int FW = (g == FLD_PGM) ? PGM_W   : (g == FLD_RLX) ? RLX_W   : RD_W;
      fuse_field_len #(.FW(FW), .CNT_W(CNT_W)) field_i (
         .field_i  (timing_i[FL +: FW]),
         .len_m1_o (lens[g])
      );
   end

   assign pgm_len_o = lens[FLD_PGM];
   assign rlx_len_o = lens[FLD_RLX];
   assign rd_len_o  = lens[FLD_RD];

endmodule

// File: rtl/fuse_phase_timer.sv
module fuse_phase_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load_i)        cnt_q <= val_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/fuse_bit_shifter.sv
module fuse_bit_shifter #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              shift_i,
   output logic              lsb_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              last_o
);

   logic [DATA_W-1:0] sh_q;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         idx_q <= '0;
      end else if (load_i) begin
         sh_q  <= data_i;
         idx_q <= '0;
      end else if (shift_i) begin
         sh_q  <= {1'b0, sh_q[DATA_W-1:1]};
         idx_q <= idx_q + 1'b1;
      end
   end

   assign lsb_o  = sh_q[0];
   assign idx_o  = idx_q;
   assign last_o = (idx_q == IDX_W'(DATA_W - 1));

endmodule

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
   import fuse_seq_pkg::*;
#(
   parameter int CNT_W     = 12,
   parameter int QUIET_CYC = 500
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             op_prog_i,
   input  logic             lsb_i,
   input  logic             last_i,
   input  logic             tmr_zero_i,
   input  logic [CNT_W-1:0] pgm_len_i,
   input  logic [CNT_W-1:0] rlx_len_i,
   input  logic [CNT_W-1:0] rd_len_i,
   output seq_state_e       state_o,
   output logic             tmr_load_o,
   output logic [CNT_W-1:0] tmr_val_o,
   output logic             shift_o,
   output logic             capt_o
);

   localparam logic [CNT_W-1:0] QUIET_M1 = CNT_W'(QUIET_CYC - 1);

   seq_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d    = state_q;
      tmr_load_o = 1'b0;
      tmr_val_o  = '0;
      shift_o    = 1'b0;
      capt_o     = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (start_i) state_d = ST_EVAL;
         end
         ST_EVAL: begin
            if (!op_prog_i || lsb_i) begin
               state_d    = ST_PRE;
               tmr_load_o = 1'b1;
               tmr_val_o  = rlx_len_i;
            end else begin
               state_d = ST_SHIFT;
            end
         end
         ST_PRE: begin
            if (tmr_zero_i) begin
               tmr_load_o = 1'b1;
               if (op_prog_i) begin
                  state_d   = ST_PGM;
                  tmr_val_o = pgm_len_i;
               end else begin
                  state_d   = ST_RD;
                  tmr_val_o = rd_len_i;
               end
            end
         end
         ST_PGM, ST_RD: begin
            if (tmr_zero_i) begin
               state_d    = ST_POST;
               tmr_load_o = 1'b1;
               tmr_val_o  = rlx_len_i;
            end
         end
         ST_POST: begin
            if (tmr_zero_i) state_d = op_prog_i ? ST_SHIFT : ST_CAPT;
         end
         ST_SHIFT: begin
            shift_o = 1'b1;
            if (last_i) begin
               state_d    = ST_QUIET;
               tmr_load_o = 1'b1;
               tmr_val_o  = QUIET_M1;
            end else begin
               state_d = ST_EVAL;
            end
         end
         ST_QUIET: begin
            if (tmr_zero_i) state_d = ST_DONE;
         end
         ST_CAPT: begin
            capt_o  = 1'b1;
            state_d = ST_DONE;
         end
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   assign state_o = state_q;

endmodule

// File: rtl/fuse_pulse_seq.sv
module fuse_pulse_seq
   import fuse_seq_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int TIM_W     = 32,
   parameter int PGM_LSB   = 0,
   parameter int PGM_W     = 12,
   parameter int RLX_LSB   = 12,
   parameter int RLX_W     = 4,
   parameter int RD_LSB    = 16,
   parameter int RD_W      = 6,
   parameter int QUIET_CYC = 500
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic                       op_prog_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [DATA_W-1:0]          wdata_i,
   input  logic [TIM_W-1:0]           timing_i,
   input  logic [DATA_W-1:0]          macro_rdata_i,
   output logic                       busy_o,
   output logic                       done_o,
   output logic [DATA_W-1:0]          rdata_o,
   output logic [ADDR_W-1:0]          fuse_addr_o,
   output logic [$clog2(DATA_W)-1:0]  fuse_bitsel_o,
   output logic                       fuse_bit_o,
   output logic                       fuse_pgm_o,
   output logic                       fuse_rd_o
);

   localparam int IDX_W = $clog2(DATA_W);
   localparam int Q_W   = (QUIET_CYC > 1) ? $clog2(QUIET_CYC) : 1;
   localparam int W_A   = (PGM_W > RLX_W) ? PGM_W : RLX_W;
   localparam int W_B   = (W_A > RD_W) ? W_A : RD_W;
   localparam int CNT_W = (W_B > Q_W) ? W_B : Q_W;

   if (DATA_W < 2) begin : g_bad_data_w
      $error("fuse_pulse_seq: DATA_W must be at least 2");
   end
   if (QUIET_CYC < 1) begin : g_bad_quiet
      $error("fuse_pulse_seq: QUIET_CYC must be at least 1");
   end
   if ((PGM_LSB + PGM_W > TIM_W) || (RLX_LSB + RLX_W > TIM_W) || (RD_LSB + RD_W > TIM_W)) begin : g_bad_fields
      $error("fuse_pulse_seq: timing field outside the timing word");
   end

   seq_state_e        state;
   logic              accept;
   logic              op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [TIM_W-1:0]  tim_q;
   logic [DATA_W-1:0] rdata_q;
   logic [CNT_W-1:0]  pgm_len, rlx_len, rd_len, tmr_val;
   logic              tmr_load, tmr_zero;
   logic              shift, capt, lsb, last;
   logic [IDX_W-1:0]  idx;

   assign accept = (state == ST_IDLE) && start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= 1'b0;
         addr_q <= '0;
         tim_q  <= '0;
      end else if (accept) begin
         op_q   <= op_prog_i;
         addr_q <= addr_i;
         tim_q  <= timing_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_q <= '0;
      else if (capt) rdata_q <= macro_rdata_i;
   end

   fuse_timing_unpack #(
      .TIM_W(TIM_W), .PGM_LSB(PGM_LSB), .PGM_W(PGM_W), .RLX_LSB(RLX_LSB),
      .RLX_W(RLX_W), .RD_LSB(RD_LSB), .RD_W(RD_W), .CNT_W(CNT_W)
   ) unpack_i (
      .timing_i  (tim_q),
      .pgm_len_o (pgm_len),
      .rlx_len_o (rlx_len),
      .rd_len_o  (rd_len)
   );

   fuse_phase_timer #(.CNT_W(CNT_W)) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   fuse_bit_shifter #(.DATA_W(DATA_W), .IDX_W(IDX_W)) shifter_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .data_i  (wdata_i),
      .shift_i (shift),
      .lsb_o   (lsb),
      .idx_o   (idx),
      .last_o  (last)
   );

   fuse_seq_ctrl #(.CNT_W(CNT_W), .QUIET_CYC(QUIET_CYC)) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .op_prog_i  (op_q),
      .lsb_i      (lsb),
      .last_i     (last),
      .tmr_zero_i (tmr_zero),
      .pgm_len_i  (pgm_len),
      .rlx_len_i  (rlx_len),
      .rd_len_i   (rd_len),
      .state_o    (state),
      .tmr_load_o (tmr_load),
      .tmr_val_o  (tmr_val),
      .shift_o    (shift),
      .capt_o     (capt)
   );

   assign busy_o        = (state != ST_IDLE);
   assign done_o        = (state == ST_DONE);
   assign rdata_o       = rdata_q;
   assign fuse_addr_o   = addr_q;
   assign fuse_bitsel_o = idx;
   assign fuse_bit_o    = op_q & lsb & busy_o;
   assign fuse_pgm_o    = (state == ST_PGM);
   assign fuse_rd_o     = (state == ST_RD);

endmodule

// File: rtl/fuse_pulse_seq_chk.sv
module fuse_pulse_seq_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              done_o,
   input logic              fuse_pgm_o,
   input logic              fuse_rd_o,
   input logic              fuse_bit_o,
   input logic [IDX_W-1:0]  fuse_bitsel_o,
   input logic [ADDR_W-1:0] fuse_addr_o,
   input logic [DATA_W-1:0] rdata_o
);

   // R8
   no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fuse_pgm_o && fuse_rd_o));

   // R8
   idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!fuse_pgm_o && !fuse_rd_o));

   // R2
   pgm_on_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_pgm_o |-> fuse_bit_o);

   // R2
   bitsel_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fuse_pgm_o && $past(fuse_pgm_o)) |-> $stable(fuse_bitsel_o));

   // R8
   addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(fuse_addr_o));

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6
   done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   // R7
   busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

   // R9
   rdata_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(rdata_o));

endmodule

bind fuse_pulse_seq fuse_pulse_seq_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy_o        (busy_o),
   .done_o        (done_o),
   .fuse_pgm_o    (fuse_pgm_o),
   .fuse_rd_o     (fuse_rd_o),
   .fuse_bit_o    (fuse_bit_o),
   .fuse_bitsel_o (fuse_bitsel_o),
   .fuse_addr_o   (fuse_addr_o),
   .rdata_o       (rdata_o)
);

// File: tb/fuse_pulse_seq_tb.sv
`timescale 1ns/1ps
module fuse_pulse_seq_tb_top;

   localparam int Q = 500;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        op_prog_i = 1'b0;
   logic [7:0]  addr_i = '0;
   logic [31:0] wdata_i = '0;
   logic [31:0] timing_i = '0;
   logic [31:0] macro_rdata_i = '0;
   logic        busy_o, done_o, fuse_bit_o, fuse_pgm_o, fuse_rd_o;
   logic [31:0] rdata_o;
   logic [7:0]  fuse_addr_o;
   logic [4:0]  fuse_bitsel_o;

   int checks = 0;
   int failures = 0;
   int wd_cnt = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   fuse_pulse_seq #(.DATA_W(32), .ADDR_W(8), .QUIET_CYC(Q)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_prog_i(op_prog_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .timing_i(timing_i),
      .macro_rdata_i(macro_rdata_i), .busy_o(busy_o), .done_o(done_o),
      .rdata_o(rdata_o), .fuse_addr_o(fuse_addr_o), .fuse_bitsel_o(fuse_bitsel_o),
      .fuse_bit_o(fuse_bit_o), .fuse_pgm_o(fuse_pgm_o), .fuse_rd_o(fuse_rd_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   always @(posedge clk) begin
      wd_cnt++;
      if (wd_cnt > 190000 && !finished) begin
         failures++;
         $display("FAIL watchdog: run did not end, actual=%0d expected<=190000", wd_cnt);
         report();
         $finish;
      end
   end

   function automatic int flen(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic logic [31:0] mk_tim(input int pgm, input int rlx, input int rd,
                                          input logic [9:0] junk);
      return {junk, 6'(rd), 4'(rlx), 12'(pgm)};
   endfunction

   function automatic int exp_busy(input bit prog, input logic [31:0] data,
                                   input int lp, input int lr, input int lrd);
      if (prog) return 64 + $countones(data) * (2 * lr + lp) + Q + 1;
      return 2 * lr + lrd + 3;
   endfunction

   task automatic run_op(input bit prog, input logic [7:0] addr, input logic [31:0] data,
                         input logic [31:0] tim, input logic [31:0] mrd,
                         input int inj_at, input string extra_req);
      int lp, lr, lrd, ebusy, busy_n, dones, pulses, rd_pulses, width, rwidth;
      int next_bit, tail, bad_sel, bad_addr, bad_w;
      logic prev_p, prev_r;
      logic [31:0] rd_before;
      lp = flen(int'(tim[11:0]));
      lr = flen(int'(tim[15:12]));
      lrd = flen(int'(tim[21:16]));
      ebusy = exp_busy(prog, data, lp, lr, lrd);
      busy_n = 0; dones = 0; pulses = 0; rd_pulses = 0; width = 0; rwidth = 0;
      next_bit = 0; tail = 0; bad_sel = 0; bad_addr = 0; bad_w = 0;
      prev_p = 1'b0; prev_r = 1'b0;
      rd_before = rdata_o;
      @(negedge clk);
      op_prog_i = prog; addr_i = addr; wdata_i = data; timing_i = tim;
      macro_rdata_i = mrd; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (busy_o && busy_n < 40000) begin
         busy_n++;
         if (done_o) dones++;
         if (fuse_addr_o !== addr) bad_addr++;
         if (fuse_pgm_o) begin
            tail = 0;
            if (!prev_p) begin
               pulses++;
               while (next_bit < 32 && !data[next_bit]) next_bit++;
               if (int'(fuse_bitsel_o) != next_bit || !fuse_bit_o) bad_sel++;
               next_bit++;
               width = 0;
            end
            width++;
         end else begin
            if (prev_p && width != lp) bad_w++;
            tail++;
         end
         if (fuse_rd_o) begin
            if (!prev_r) begin rd_pulses++; rwidth = 0; end
            rwidth++;
         end else if (prev_r && rwidth != lrd) bad_w++;
         prev_p = fuse_pgm_o;
         prev_r = fuse_rd_o;
         if (busy_n == inj_at) begin
            start_i = 1'b1; op_prog_i = ~prog;
            timing_i = $urandom; wdata_i = $urandom; addr_i = 8'($urandom);
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      chk(busy_n == ebusy, prog ? "R4" : "R5", "busy cycles", busy_n, ebusy);
      chk(dones == 1, "R6", "done pulses", dones, 1);
      chk(bad_addr == 0, "R8", "address mismatches", bad_addr, 0);
      if (extra_req != "") chk(busy_n == ebusy, extra_req, "busy cycles", busy_n, ebusy);
      if (prog) begin
         chk(pulses == $countones(data), "R2", "program strobes", pulses, $countones(data));
         chk(bad_sel == 0, "R2", "bit select errors", bad_sel, 0);
         chk(bad_w == 0, "R3", "strobe width errors", bad_w, 0);
         chk(rd_pulses == 0, "R8", "read strobes in program", rd_pulses, 0);
         chk(tail >= Q + 1, "R6", "quiet tail cycles", tail, Q + 1);
         chk(rdata_o == rd_before, "R9", "read word after program", rdata_o, rd_before);
      end else begin
         chk(rd_pulses == 1, "R5", "read strobes", rd_pulses, 1);
         chk(pulses == 0, "R8", "program strobes in read", pulses, 0);
         chk(bad_w == 0, "R5", "read width errors", bad_w, 0);
         chk(rdata_o == mrd, "R5", "captured word", rdata_o, mrd);
      end
      if (inj_at > 0) begin
         @(negedge clk);
         chk(!busy_o, "R7", "busy after ignored request", busy_o, 0);
      end
   endtask

   initial begin
      int unsigned seed_r;
      seed_r = $urandom(32'd20417);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy_o, "R1", "busy after reset", busy_o, 0);
      chk(!done_o, "R1", "done after reset", done_o, 0);
      chk(!fuse_pgm_o && !fuse_rd_o, "R1", "strobes after reset", {fuse_pgm_o, fuse_rd_o}, 0);
      chk(rdata_o == 0, "R1", "read word after reset", rdata_o, 0);

      // directed corners
      run_op(1'b1, 8'h11, 32'h0000_0000, mk_tim(5, 2, 4, 10'h0), 32'h0, 0, "R2");
      run_op(1'b1, 8'h22, 32'hFFFF_FFFF, mk_tim(3, 0, 4, 10'h155), 32'h0, 0, "R4");
      run_op(1'b1, 8'h33, 32'h8000_0001, mk_tim(0, 3, 4, 10'h0), 32'h0, 0, "R3");
      run_op(1'b0, 8'h44, 32'h0, mk_tim(7, 0, 0, 10'h0), 32'hA5A5_5A5A, 0, "R5");
      run_op(1'b0, 8'h55, 32'h0, mk_tim(7, 3, 17, 10'h3FF), 32'h1234_5678, 0, "R10");
      run_op(1'b1, 8'h66, 32'h00F0_A5C3, mk_tim(4, 2, 9, 10'h3FF), 32'h0, 40, "R7");
      run_op(1'b0, 8'h77, 32'h0, mk_tim(4, 2, 9, 10'h0), 32'hDEAD_BEEF, 3, "R7");
      run_op(1'b1, 8'h88, 32'h0000_0100, mk_tim(6, 1, 2, 10'h0), 32'h0, 300, "R6");

      // constrained random accesses
      for (int i = 0; i < 20; i++) begin
         bit          prog;
         logic [31:0] data, tim, mrd;
         int          inj, eb;
         prog = 1'($urandom);
         data = $urandom;
         mrd  = $urandom;
         tim  = mk_tim(int'($urandom % 16), int'($urandom % 16), int'($urandom % 64),
                       10'($urandom));
         eb   = exp_busy(prog, data, flen(int'(tim[11:0])), flen(int'(tim[15:12])),
                         flen(int'(tim[21:16])));
         inj  = ($urandom % 2 == 0) ? 0 : 2 + int'($urandom % unsigned'(eb - 2));
         run_op(prog, 8'($urandom), data, tim, mrd, inj, (inj > 0) ? "R7" : "R10");
      end

      report();
      $finish;
   end

endmodule